// File: doc/BRIEF.md
# UART FIFO Threshold Control Unit

This block is the FIFO half of a 16550-style UART. It holds two 16-entry FIFOs, one for transmit and one for receive, and tracks how full each one is. From the occupancy it produces three outputs: a received-data-available interrupt, a transmit-holding-empty interrupt and an active-low receive DMA request. Serial shifting, baud generation, line status and modem control belong to other blocks. The UART core moves bytes in and out through push and pop strobes.

The main FIFO control register cannot be read back. Each of its fields therefore also has a small read/write shadow register at its own address. Software can change the enable, the receive trigger or the transmit-empty trigger through the matching shadow register without keeping a copy of the last value written. The control fields feed the receive trigger decoder and the transmit-empty threshold decoder. A separate threshold-mode bit chooses whether the transmit interrupt follows the programmed level or fires only when the transmit FIFO is fully empty.

Top module: `uart_fifo_thresh`

## Requirements
- R1: After reset every control field, shadow and the threshold-mode bit read as zero. Both occupancy counts are zero, rx_dma_req_n is high and tx_empty_irq is high.
- R2: A write to address 0 loads all fields at once: enable from bit 0, DMA mode from bit 3, transmit trigger from bits 5:4 and receive trigger from bits 7:6. A read of address 0, or of any address from 5 to 7, returns zero.
- R3: Address 1 is the enable shadow. A write changes only the enable, taken from data bit 0. A read returns the enable in bit 0 and zeros above it.
- R4: Address 2 is the receive trigger shadow. A write changes only the receive trigger, taken from data bits 1:0. A read returns the trigger in bits 1:0 and zeros above them.
- R5: Address 3 is the transmit trigger shadow. A write changes only the transmit trigger, taken from data bits 1:0. A read returns the trigger in bits 1:0 and zeros above them.
- R6: While the enable is 0, both FIFOs are flushed one cycle after the enable falls and pushes are dropped. Both counts read zero.
- R7: The receive trigger codes 00, 01, 10 and 11 select levels of 1, 4, 8 and 14 entries.
- R8: rx_avail_irq is high exactly when the receive occupancy is at or above the selected level.
- R9: rx_dma_req_n is low exactly when the DMA mode bit is 1 and rx_avail_irq is high.
- R10: The transmit trigger codes 00, 01, 10 and 11 select thresholds of 0, 2, 4 and 8 entries. With threshold mode on, tx_empty_irq is high exactly when the transmit occupancy is at or below the threshold.
- R11: Address 4 holds threshold mode in bit 0 and can be read and written. With threshold mode off, tx_empty_irq is high only when the transmit FIFO is empty.
- R12: Each FIFO returns bytes in the order they were pushed. A push to a full FIFO is dropped, and a pop from an empty FIFO yields zero on the pop data. Neither changes the count. A simultaneous push and pop on a partly filled FIFO leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| tx_push | input | 1 | Push strobe into transmit FIFO |
| tx_push_data | input | 8 | Byte to push into transmit FIFO |
| tx_pop | input | 1 | Pop strobe from transmit FIFO |
| tx_pop_data | output | 8 | Head of transmit FIFO, zero when empty |
| tx_count | output | 5 | Transmit occupancy |
| rx_push | input | 1 | Push strobe into receive FIFO |
| rx_push_data | input | 8 | Byte to push into receive FIFO |
| rx_pop | input | 1 | Pop strobe from receive FIFO |
| rx_pop_data | output | 8 | Head of receive FIFO, zero when empty |
| rx_count | output | 5 | Receive occupancy |
| rx_avail_irq | output | 1 | Received-data-available interrupt |
| tx_empty_irq | output | 1 | Transmit-holding-empty interrupt |
| rx_dma_req_n | output | 1 | Active-low receive DMA request |

## Verification
The bench fills both FIFOs up to and past full while popping at random. A design that let a full push through would overwrite the oldest byte, and one that miscounted a simultaneous push and pop would drift its occupancy away from the model's queue length. Every trigger code is swept across its boundary occupancy, so an off-by-one in the 14-entry "two less than full" level or the 8-entry transmit threshold shows up as a late or early interrupt edge. Random shadow writes mixed with full control writes check that a shadow write leaves the other fields alone. Random disable events check that the flush clears both queues and that pushes made while disabled never reappear.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL  = 3'd0,
    ADR_SH_EN = 3'd1,
    ADR_SH_RX = 3'd2,
    ADR_SH_TX = 3'd3,
    ADR_THMD  = 3'd4
  } uft_addr_e;

  // receive trigger level in entries for a given code and FIFO depth
  function automatic int rx_level(input logic [1:0] code, input int depth);
    case (code)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // transmit-empty threshold in entries for a given code and FIFO depth
  function automatic int tx_level(input logic [1:0] code, input int depth);
    case (code)
      2'b00:   return 0;
      2'b01:   return 2;
      2'b10:   return depth / 4;
      default: return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          fifo_en,
  output logic          dma_mode,
  output logic [1:0]    rx_trig,
  output logic [1:0]    tx_trig,
  output logic          thr_mode
);

  // write decode, one strobe per register
  logic wr_ctrl, wr_en, wr_rx, wr_tx, wr_thm;
  assign wr_ctrl = we && (addr == AW'(ADR_CTRL));
  assign wr_en   = we && (addr == AW'(ADR_SH_EN));
  assign wr_rx   = we && (addr == AW'(ADR_SH_RX));
  assign wr_tx   = we && (addr == AW'(ADR_SH_TX));
  assign wr_thm  = we && (addr == AW'(ADR_THMD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      dma_mode <= 1'b0;
      rx_trig  <= 2'b00;
      tx_trig  <= 2'b00;
      thr_mode <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        fifo_en  <= wdata[0];
        dma_mode <= wdata[3];
        tx_trig  <= wdata[5:4];
        rx_trig  <= wdata[7:6];
      end
      if (wr_en)  fifo_en  <= wdata[0];
      if (wr_rx)  rx_trig  <= wdata[1:0];
      if (wr_tx)  tx_trig  <= wdata[1:0];
      if (wr_thm) thr_mode <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(ADR_SH_EN): rdata[0]   = fifo_en;
      AW'(ADR_SH_RX): rdata[1:0] = rx_trig;
      AW'(ADR_SH_TX): rdata[1:0] = tx_trig;
      AW'(ADR_THMD):  rdata[0]   = thr_mode;
      default:        rdata      = '0;
    endcase
  end

endmodule

// File: rtl/uft_fifo.sv
module uft_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          do_push,
  output logic          do_pop
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // acceptance judged on the occupancy before this edge
  assign do_push = push && !flush && (count != CW'(DEPTH));
  assign do_pop  = pop  && !flush && (count != '0);
  assign pop_data = (count != '0) ? mem[rp] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

endmodule

// File: rtl/uft_thresh.sv
module uft_thresh
  import uft_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic [1:0]    rx_trig,
  input  logic [1:0]    tx_trig,
  input  logic          dma_mode,
  input  logic          thr_mode,
  output logic          rx_avail_irq,
  output logic          tx_empty_irq,
  output logic          rx_dma_req_n
);

  logic rx_hit, tx_low;
  assign rx_hit = int'(rx_count) >= rx_level(rx_trig, DEPTH);
  assign tx_low = int'(tx_count) <= tx_level(tx_trig, DEPTH);

  assign rx_avail_irq = rx_hit;
  assign rx_dma_req_n = !(dma_mode && rx_hit);
  assign tx_empty_irq = thr_mode ? tx_low : (tx_count == '0);

endmodule

// File: rtl/uart_fifo_thresh.sv
module uart_fifo_thresh #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pop_data,
  output logic [CW-1:0] tx_count,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  output logic [CW-1:0] rx_count,
  output logic          rx_avail_irq,
  output logic          tx_empty_irq,
  output logic          rx_dma_req_n
);

  logic       fifo_en, dma_mode, thr_mode;
  logic [1:0] rx_trig, tx_trig;
  logic       fifo_flush;
  logic       rx_acc_push, rx_acc_pop, tx_acc_push, tx_acc_pop;

  assign fifo_flush = !fifo_en;

  uft_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .rdata(reg_rdata), .fifo_en(fifo_en),
    .dma_mode(dma_mode), .rx_trig(rx_trig), .tx_trig(tx_trig),
    .thr_mode(thr_mode)
  );

  uft_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(tx_push),
    .push_data(tx_push_data), .pop(tx_pop), .pop_data(tx_pop_data),
    .count(tx_count), .do_push(tx_acc_push), .do_pop(tx_acc_pop)
  );

  uft_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(rx_push),
    .push_data(rx_push_data), .pop(rx_pop), .pop_data(rx_pop_data),
    .count(rx_count), .do_push(rx_acc_push), .do_pop(rx_acc_pop)
  );

  uft_thresh #(.DEPTH(DEPTH)) u_thr (
    .rx_count(rx_count), .tx_count(tx_count), .rx_trig(rx_trig),
    .tx_trig(tx_trig), .dma_mode(dma_mode), .thr_mode(thr_mode),
    .rx_avail_irq(rx_avail_irq), .tx_empty_irq(tx_empty_irq),
    .rx_dma_req_n(rx_dma_req_n)
  );

endmodule

// File: rtl/uft_chk.sv
module uft_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          dma_mode,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic [DW-1:0] rx_pop_data,
  input logic [DW-1:0] tx_pop_data,
  input logic          rx_avail_irq,
  input logic          tx_empty_irq,
  input logic          rx_dma_req_n
);

  // R6
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (rx_count == '0 && tx_count == '0));

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  // R12
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_count == CW'(DEPTH) && rx_push && !rx_pop) |=> rx_count == CW'(DEPTH));

  // R12
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> (rx_pop_data == '0));

  // R8
  avail_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail_irq |-> rx_count != '0);

  // R9
  dma_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> rx_dma_req_n);

  // R11
  tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> tx_empty_irq);

endmodule

bind uart_fifo_thresh uft_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_count(rx_count),
  .tx_count(tx_count), .rx_pop_data(rx_pop_data), .tx_pop_data(tx_pop_data),
  .rx_avail_irq(rx_avail_irq), .tx_empty_irq(tx_empty_irq),
  .rx_dma_req_n(rx_dma_req_n)
);

// File: tb/sim_uart_fifo_thresh.sv
module sim_uart_fifo_thresh;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_push_data = '0, rx_push_data = '0;
  logic [7:0] tx_pop_data, rx_pop_data;
  logic [4:0] tx_count, rx_count;
  logic       rx_avail_irq, tx_empty_irq, rx_dma_req_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_thresh u0 (.*);

  int vectors = 0;
  int fails = 0;

  // behavioural reference state
  bit         m_en, m_dma, m_thr;
  bit   [1:0] m_rxt, m_txt;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl_rx(input bit [1:0] c);
    int t[4] = '{1, 4, 8, 14};
    return t[c];
  endfunction

  function automatic int lvl_tx(input bit [1:0] c);
    int t[4] = '{0, 2, 4, 8};
    return t[c];
  endfunction

  task automatic compare_all();
    int exp_rd;
    string rtag;
    bit e_av, e_te;
    case (reg_addr)
      3'd1: begin exp_rd = int'(m_en);  rtag = "R3";  end
      3'd2: begin exp_rd = int'(m_rxt); rtag = "R4";  end
      3'd3: begin exp_rd = int'(m_txt); rtag = "R5";  end
      3'd4: begin exp_rd = int'(m_thr); rtag = "R11"; end
      default: begin exp_rd = 0;        rtag = "R2";  end
    endcase
    chk(int'(reg_rdata) == exp_rd, rtag, int'(reg_rdata), exp_rd);
    chk(int'(rx_count) == rxq.size(), "R12 rx_count", int'(rx_count), rxq.size());
    chk(int'(tx_count) == txq.size(), "R12 tx_count", int'(tx_count), txq.size());
    chk(int'(rx_pop_data) == (rxq.size() ? int'(rxq[0]) : 0), "R12 rx_pop_data",
        int'(rx_pop_data), rxq.size() ? int'(rxq[0]) : 0);
    chk(int'(tx_pop_data) == (txq.size() ? int'(txq[0]) : 0), "R12 tx_pop_data",
        int'(tx_pop_data), txq.size() ? int'(txq[0]) : 0);
    e_av = rxq.size() >= lvl_rx(m_rxt);
    chk(rx_avail_irq == e_av, "R8 rx_avail_irq", int'(rx_avail_irq), int'(e_av));
    chk(rx_dma_req_n == !(m_dma && e_av), "R9 rx_dma_req_n", int'(rx_dma_req_n),
        int'(!(m_dma && e_av)));
    e_te = m_thr ? (txq.size() <= lvl_tx(m_txt)) : (txq.size() == 0);
    chk(tx_empty_irq == e_te, m_thr ? "R10 tx_empty_irq" : "R11 tx_empty_irq",
        int'(tx_empty_irq), int'(e_te));
  endtask

  task automatic model_step();
    int rs, ts;
    bit en_pre;
    en_pre = m_en;
    rs = rxq.size();
    ts = txq.size();
    if (!en_pre) begin
      rxq.delete();
      txq.delete();
    end else begin
      if (rx_pop && rs > 0) void'(rxq.pop_front());
      if (rx_push && rs < DEPTH) rxq.push_back(rx_push_data);
      if (tx_pop && ts > 0) void'(txq.pop_front());
      if (tx_push && ts < DEPTH) txq.push_back(tx_push_data);
    end
    if (reg_we) begin
      case (reg_addr)
        3'd0: begin
          m_en = reg_wdata[0]; m_dma = reg_wdata[3];
          m_txt = reg_wdata[5:4]; m_rxt = reg_wdata[7:6];
        end
        3'd1: m_en = reg_wdata[0];
        3'd2: m_rxt = reg_wdata[1:0];
        3'd3: m_txt = reg_wdata[1:0];
        3'd4: m_thr = reg_wdata[0];
        default: ;
      endcase
    end
  endtask

  // one bench cycle: we stand at a falling edge with inputs already set
  task automatic cycle();
    #1 compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    reg_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    idle(); reg_addr = a; reg_we = 1; reg_wdata = d; cycle(); reg_we = 0;
  endtask

  task automatic rxpush(input logic [7:0] d);
    idle(); rx_push = 1; rx_push_data = d; cycle(); rx_push = 0;
  endtask

  task automatic txpush(input logic [7:0] d);
    idle(); tx_push = 1; tx_push_data = d; cycle(); tx_push = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    #1;
    chk(reg_rdata == 0 && rx_count == 0 && tx_count == 0, "R1 regs/counts", 0, 0);
    chk(rx_dma_req_n == 1'b1, "R1 dma_req_n", int'(rx_dma_req_n), 1);
    chk(tx_empty_irq == 1'b1, "R1 tx_empty_irq", int'(tx_empty_irq), 1);
    for (int a = 1; a < 5; a++) begin
      reg_addr = 3'(a); #1;
      chk(reg_rdata == 0, "R1 shadow zero", int'(reg_rdata), 0);
    end
    @(negedge clk);

    // R6: pushes while disabled are dropped
    rxpush(8'h11); txpush(8'h22); idle(); cycle();
    chk(rx_count == 0 && tx_count == 0, "R6 disabled push", int'(rx_count), 0);

    // R2: full control write; rx=01 tx=10 dma=1 en=1
    wr(3'd0, 8'b0110_1001);
    reg_addr = 3'd0; idle(); cycle();
    reg_addr = 3'd2; #1; chk(reg_rdata == 8'd1, "R2 rx field", int'(reg_rdata), 1);
    reg_addr = 3'd3; #1; chk(reg_rdata == 8'd2, "R2 tx field", int'(reg_rdata), 2);
    @(negedge clk);

    // R7/R9: level 4 reached on fourth push
    for (int i = 0; i < 3; i++) rxpush(8'(8'hA0 + i));
    #1 chk(rx_avail_irq == 0, "R7 below quarter", int'(rx_avail_irq), 0);
    @(negedge clk);
    rxpush(8'hA3);
    #1 chk(rx_avail_irq == 1 && rx_dma_req_n == 0, "R7/R9 quarter", int'(rx_avail_irq), 1);
    @(negedge clk);

    // R4: shadow write to 11 keeps dma/enable (R3 read)
    wr(3'd2, 8'hFF);
    reg_addr = 3'd1; idle(); #1;
    chk(reg_rdata == 8'd1, "R3 enable untouched", int'(reg_rdata), 1);
    @(negedge clk);
    for (int i = 4; i < 13; i++) rxpush(8'(8'hA0 + i));
    #1 chk(rx_avail_irq == 0, "R7 13 below 14", int'(rx_avail_irq), 0);
    @(negedge clk);
    rxpush(8'hAD);
    #1 chk(rx_avail_irq == 1, "R7 two less than full", int'(rx_avail_irq), 1);
    @(negedge clk);

    // R12: overfill then order check
    for (int i = 14; i < 20; i++) rxpush(8'(8'hA0 + i));
    #1 chk(rx_count == 16, "R12 full drop", int'(rx_count), 16);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      idle(); #1;
      chk(rx_pop_data == 8'(8'hA0 + i), "R12 order", int'(rx_pop_data), 8'hA0 + i);
      @(negedge clk);
      rx_pop = 1; cycle();
    end
    rx_pop = 1; cycle(); idle();
    #1 chk(rx_count == 0 && rx_pop_data == 0, "R12 empty pop", int'(rx_count), 0);
    @(negedge clk);

    // R10/R11: threshold mode
    wr(3'd4, 8'h01);
    wr(3'd3, 8'h03);
    for (int i = 0; i < 9; i++) txpush(8'(i));
    #1 chk(tx_empty_irq == 0, "R10 nine above eight", int'(tx_empty_irq), 0);
    @(negedge clk);
    tx_pop = 1; cycle(); idle();
    #1 chk(tx_empty_irq == 1, "R10 at eight", int'(tx_empty_irq), 1);
    @(negedge clk);
    wr(3'd4, 8'h00);
    #1 chk(tx_empty_irq == 0, "R11 mode off", int'(tx_empty_irq), 0);
    @(negedge clk);

    // R6: disable via shadow flushes
    wr(3'd1, 8'h00);
    idle(); cycle();
    #1 chk(tx_count == 0, "R6 flush", int'(tx_count), 0);
    @(negedge clk);

    // random mixed traffic
    for (int n = 0; n < 6000; n++) begin
      idle();
      reg_addr = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 39) == 0) begin
        reg_we = 1;
        reg_wdata = 8'($urandom);
        if ($urandom_range(0, 3) != 0) reg_wdata[0] = 1'b1;
      end
      rx_push = ($urandom_range(0, 2) != 0);
      rx_pop  = ($urandom_range(0, 2) == 0);
      tx_push = ($urandom_range(0, 1) != 0);
      tx_pop  = ($urandom_range(0, 1) != 0);
      rx_push_data = 8'($urandom);
      tx_push_data = 8'($urandom);
      cycle();
    end
    idle();
    finish_run();
  end

endmodule